// File: doc/BRIEF.md
# Two-Channel Interleaved Biphase-Mark Line Encoder

This block turns two one-bit-per-bunch streams into one serial line for a timing distribution link. In each bunch-clock period it takes a level-1 trigger bit for a low-latency channel (A) and one bit of an already-framed, already-protected command stream (B). It places A in the first bit cell and B in the second. It then drives both cells onto the line with biphase-mark coding.

The block runs on a line clock at four times the bunch rate. Each bit cell takes two line-clock cycles, one per half-cell, so the A bit always sits at the same position in every bunch period. A one-cycle bunch marker input fixes which line-clock cycle starts a period. Between markers, an internal two-bit phase counter runs freely. When the upstream command source has nothing to send, channel B carries a logic 1.

Top module: `tdm_bmc_encoder`

## Requirements
- R1: While rst_ni is low, line_o is 0, which is the defined starting level.
- R2: The line level inverts at the start of every bit cell. This holds across the A/B cell boundary, across the boundary between bunch periods, and across a realignment.
- R3: In the A cell, line_o has a mid-cell transition (half 1 differs from half 0) exactly when the trig_i value sampled at the period's first edge was 1.
- R4: In the B cell, line_o has a mid-cell transition exactly when the B bit sampled at the period's first edge was 1.
- R5: The four line-clock cycles of a period are ordered A half 0, A half 1, B half 0, B half 1. The A cell's first half appears on line_o in the cycle after the period's first rising edge, which is one line-clock of latency.
- R6: A high bc_mark_i makes that rising edge the first edge of a new period (phase 0), whatever phase the counter held.
- R7: Without bc_mark_i, the phase advances by one every line-clock cycle modulo 4, starting from phase 0 after reset. The coded stream stays continuous.
- R8: When cmd_valid_i is low at the sampling edge, the B bit is 1 regardless of cmd_i.
- R9: trig_i, cmd_i and cmd_valid_i are sampled only at the phase-0 edge. Their values in the other three cycles do not affect line_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Line clock, four cycles per bunch period |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bc_mark_i | input | 1 | High for the line-clock cycle that opens a bunch period |
| trig_i | input | 1 | Channel A trigger bit, sampled at phase 0 |
| cmd_i | input | 1 | Channel B serial command bit, sampled at phase 0 |
| cmd_valid_i | input | 1 | High when cmd_i carries a command bit; low selects the idle value 1 |
| line_o | output | 1 | Biphase-mark coded serial line |

## Verification
Two things can fall in the same cycle: a realignment by bc_mark_i and the cell-start inversion of the coder. A marker forced in the middle of a period cuts the current cell short, and the first half of the new A cell must still invert the line. The bench provokes this by stopping periods after one, two and three cycles and then asserting the marker. It judges the result by decoding the line from its own sampled history. It expects an inversion at the cut point and correct A and B values afterwards. During the cycles that are not sampled, the bench drives random garbage on the data inputs, and this stays invisible on the line.

// File: rtl/bmc_pkg.sv
package bmc_pkg;
  localparam int unsigned SLOTS_PER_BC  = 2;  // A then B
  localparam int unsigned HALVES        = 2;  // line cycles per bit cell
  localparam int unsigned PHASES_PER_BC = SLOTS_PER_BC * HALVES;
  localparam int unsigned PHASE_W       = $clog2(PHASES_PER_BC);
  localparam int unsigned SLOT_W        = (SLOTS_PER_BC > 1) ? $clog2(SLOTS_PER_BC) : 1;
  typedef logic [PHASE_W-1:0] phase_t;
endpackage

// File: rtl/bmc_phase_gen.sv
module bmc_phase_gen
  import bmc_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   bc_mark_i,
  output phase_t phase_o
);
  phase_t phase_q;

  // marker overrides the free-running count in its own cycle
  assign phase_o = bc_mark_i ? phase_t'(0) : phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= '0;
    else         phase_q <= phase_o + phase_t'(1);
  end
endmodule

// File: rtl/bmc_tdm_mux.sv
module bmc_tdm_mux
  import bmc_pkg::*;
#(
  parameter logic B_IDLE = 1'b1
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  phase_t phase_i,
  input  logic   trig_i,
  input  logic   cmd_i,
  input  logic   cmd_valid_i,
  output logic   cell_start_o,
  output logic   cell_bit_o
);
  logic [SLOTS_PER_BC-1:0] slot_q;
  logic [SLOTS_PER_BC-1:0] slot_d;
  logic [SLOT_W-1:0]       slot_idx;
  logic                    b_bit;

  assign b_bit  = cmd_valid_i ? cmd_i : B_IDLE;
  assign slot_d = {b_bit, trig_i};  // index 0 = A

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              slot_q <= {B_IDLE, 1'b0};
    else if (phase_i == '0)   slot_q <= slot_d;
  end

  assign slot_idx     = SLOT_W'(phase_i >> $clog2(HALVES));
  assign cell_start_o = (phase_i[0] == 1'b0);
  assign cell_bit_o   = slot_q[slot_idx];
endmodule

// File: rtl/bmc_line_coder.sv
module bmc_line_coder #(
  parameter logic RESET_LEVEL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cell_start_i,
  input  logic cell_bit_i,
  output logic line_o
);
  logic line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           line_q <= RESET_LEVEL;
    else if (cell_start_i) line_q <= ~line_q;
    else                   line_q <= line_q ^ cell_bit_i;
  end

  assign line_o = line_q;
endmodule

// File: rtl/tdm_bmc_encoder.sv
module tdm_bmc_encoder
  import bmc_pkg::*;
#(
  parameter logic RESET_LEVEL = 1'b0,
  parameter logic B_IDLE      = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bc_mark_i,
  input  logic trig_i,
  input  logic cmd_i,
  input  logic cmd_valid_i,
  output logic line_o
);
  phase_t phase;
  logic   cell_start;
  logic   cell_bit;

  bmc_phase_gen u_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bc_mark_i(bc_mark_i),
    .phase_o  (phase)
  );

  bmc_tdm_mux #(.B_IDLE(B_IDLE)) u_mux (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .phase_i     (phase),
    .trig_i      (trig_i),
    .cmd_i       (cmd_i),
    .cmd_valid_i (cmd_valid_i),
    .cell_start_o(cell_start),
    .cell_bit_o  (cell_bit)
  );

  bmc_line_coder #(.RESET_LEVEL(RESET_LEVEL)) u_coder (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cell_start_i(cell_start),
    .cell_bit_i  (cell_bit),
    .line_o      (line_o)
  );
endmodule

// File: rtl/tdm_bmc_encoder_chk.sv
module tdm_bmc_encoder_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bc_mark_i,
  input logic trig_i,
  input logic cmd_i,
  input logic cmd_valid_i,
  input logic line_o
);
  logic [1:0] ck_ph_q;
  logic [1:0] ck_ph;

  assign ck_ph = bc_mark_i ? 2'd0 : ck_ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ck_ph_q <= 2'd0;
    else         ck_ph_q <= ck_ph + 2'd1;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) assert_reset_level_R1: assert (line_o == 1'b0) else $error("R1 line not at reset level");
  end

  assert_cell_toggle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ck_ph == 2'd0 || ck_ph == 2'd2) |=> (line_o != $past(line_o)));

  assert_a_mid_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ck_ph == 2'd1) |=> ((line_o != $past(line_o)) == $past(trig_i, 2)));

  assert_b_mid_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ck_ph == 2'd3) |=> ((line_o != $past(line_o)) == $past(!cmd_valid_i || cmd_i, 4)));

  assert_mark_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bc_mark_i |=> (line_o != $past(line_o)));
endmodule

bind tdm_bmc_encoder tdm_bmc_encoder_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bc_mark_i  (bc_mark_i),
  .trig_i     (trig_i),
  .cmd_i      (cmd_i),
  .cmd_valid_i(cmd_valid_i),
  .line_o     (line_o)
);

// File: tb/sim_tdm_bmc_encoder.sv
`timescale 1ns/1ps
module sim_tdm_bmc_encoder;
  logic clk_i = 1'b0;
  logic rst_ni, bc_mark_i, trig_i, cmd_i, cmd_valid_i;
  logic line_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic prev_lvl;

  always #5 clk_i = ~clk_i;

  tdm_bmc_encoder u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .bc_mark_i(bc_mark_i),
    .trig_i(trig_i), .cmd_i(cmd_i), .cmd_valid_i(cmd_valid_i), .line_o(line_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_b(input bit cv, input bit c);
    return cv ? c : 1'b1;
  endfunction

  // one line-clock cycle: drive at negedge, sample 1 ns after the rising edge
  task automatic cyc(input bit mark, input bit a, input bit c, input bit cv, output logic s);
    bc_mark_i = mark; trig_i = a; cmd_i = c; cmd_valid_i = cv;
    @(posedge clk_i); #1 s = line_o;
    @(negedge clk_i);
  endtask

  task automatic bunch(input bit mark, input bit a, input bit c, input bit cv, input string tag);
    logic h [4];
    cyc(mark, a, c, cv, h[0]);
    for (int k = 1; k < 4; k++) cyc(1'b0, 1'($urandom), 1'($urandom), 1'($urandom), h[k]); // R9 junk
    check(h[0] != prev_lvl, {"R2 A-cell start ", tag}, h[0], !prev_lvl);
    check(h[2] != h[1],     {"R2 B-cell start ", tag}, h[2], !h[1]);
    check((h[1] != h[0]) == a, {"R3/R5/R9 A bit ", tag}, h[1] != h[0], a);
    check((h[3] != h[2]) == exp_b(cv, c), {"R4/R8/R9 B bit ", tag}, h[3] != h[2], exp_b(cv, c));
    prev_lvl = h[3];
  endtask

  initial begin
    logic s;
    rst_ni = 1'b0; bc_mark_i = 0; trig_i = 1; cmd_i = 1; cmd_valid_i = 1;
    void'($urandom(32'd1234));
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      check(line_o == 1'b0, "R1 reset level", line_o, 0);
    end
    rst_ni = 1'b1;
    prev_lvl = 1'b0;
    bunch(1'b0, 1'b1, 1'b0, 1'b1, "R7 free-run first");
    bunch(1'b0, 1'b0, 1'b1, 1'b1, "R7 free-run");
    bunch(1'b1, 1'b1, 1'b1, 1'b1, "R6 aligned mark");
    bunch(1'b0, 1'b0, 1'b0, 1'b1, "R5 zeros");
    bunch(1'b0, 1'b1, 1'b0, 1'b0, "R8 idle B cmd0");
    bunch(1'b0, 1'b0, 1'b0, 1'b0, "R8 idle B no trig");
    for (int n = 1; n < 4; n++) begin
      for (int k = 0; k < n; k++) begin
        cyc(1'b0, 1'($urandom), 1'($urandom), 1'($urandom), s);
        prev_lvl = s;
      end
      bunch(1'b1, 1'($urandom), 1'($urandom), 1'b1, "R6 realign");
      bunch(1'b0, 1'b1, 1'b1, 1'b1, "R7 after realign");
    end
    for (int i = 0; i < 300; i++)
      bunch(($urandom % 4) == 0, 1'($urandom), 1'($urandom), ($urandom % 3) != 0, "random");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule